// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This peripheral gives a 32-bit soft processor a byte-wide asynchronous serial link through three word-aligned registers on a small request/acknowledge bus. A store to the transmit register starts an 8N1 frame on the output line. A load from the receive register hands back the oldest byte in a 16-entry receive queue and removes it. A load from the status register tells software whether the transmitter is still sending and whether received data is waiting. The interconnect routes requests for the window that starts at 0x1000_0000 and ends at 0x1000_0FFF to this block, which decodes only the 12-bit offset inside that window.

The bit rate is fixed when the block is built. The clock count per bit is the clock frequency divided by the baud parameter, which gives 434 at the default 50 MHz and 115200. The receive line passes through two flops to resynchronise it. A falling edge on the line starts a frame, and every bit is sampled near its centre, timed from that edge. Everything runs on one rising-edge clock with a synchronous active-high reset.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `uart_tx` is 1, `bus_ready` is 0, and a status read returns 0.
- R2: A request is acknowledged by `bus_ready` exactly one cycle after `bus_valid` is first sampled. The acknowledge lasts one cycle and carries the read data.
- R3: A write to offset 0x0 sends bits 7:0 of the write data as an 8N1 frame, least significant bit first. Each bit lasts CLK_HZ/BAUD cycles, and the start bit begins on the clock edge that accepts the write.
- R4: Status bit 0 (transmitter busy) reads 1 from the accepted write until the stop bit ends, and 0 after that.
- R5: A write to offset 0x0 while the transmitter is busy is ignored: no extra frame is sent and the frame in progress is unchanged.
- R6: A received frame with a valid stop bit is stored in the receive queue. Status bit 1 (data waiting) reads 1 while the queue is not empty.
- R7: A read of offset 0x4 returns the oldest queued byte in bits 7:0, with bits 31:8 at 0, and removes it, so bytes come out in arrival order.
- R8: A read of offset 0x4 while the queue is empty returns 0 and leaves the queue empty.
- R9: The queue holds 16 bytes. Bytes that arrive while it is full are discarded, and the 16 stored bytes stay intact.
- R10: Status bits 31:2 read 0. Reads of any offset other than 0x0, 0x4 and 0x8 return 0. Writes to any offset other than 0x0 change nothing.
- R11: A frame whose stop bit samples as 0 is discarded.
- R12: A low pulse on the receive line that has ended by the middle of the start bit is not taken as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present; held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset inside the peripheral window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid while bus_ready is 1 |
| uart_tx | output | 1 | Serial output, idles high |
| uart_rx | input | 1 | Serial input, asynchronous |

## Verification
The assertions assume a well-behaved requester. It holds `bus_valid`, `bus_we` and `bus_addr` steady until it sees `bus_ready`, and it drops `bus_valid` in the cycle after the acknowledge. Only under that assumption does a response map onto one request. They also assume serial frames arrive at the configured bit time, idle-high and with whole bits. The bench drives every bus access through a single task that follows this discipline. Its frame generator holds each serial bit for exactly the bit time, except for the deliberate short pulse and the bad stop bit.

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 115_200,
  parameter int FIFO_DEPTH = 16,
  parameter int OFS_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic             bus_ready,
  output logic [31:0]      bus_rdata,
  output logic             uart_tx,
  input  logic             uart_rx
);
  localparam int DIV  = CLK_HZ / BAUD;
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int AW   = $clog2(FIFO_DEPTH);

  logic req, sel_tx, sel_rx, sel_st, wr_tx, rd_rx, pop, push, empty, full;
  logic tx_busy;
  logic [9:0] tx_sh;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0] tx_bit, rx_bit;
  logic rx_meta, rx_s, rx_act;
  logic [7:0] rx_sh;
  logic [7:0] mem [FIFO_DEPTH];
  logic [AW:0] wp, rp, rx_fill;
  logic unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata[31:8]};
  assign req    = bus_valid && !bus_ready;
  assign sel_tx = bus_addr == OFS_W'('h0);
  assign sel_rx = bus_addr == OFS_W'('h4);
  assign sel_st = bus_addr == OFS_W'('h8);
  assign wr_tx  = req && bus_we && sel_tx && !tx_busy;
  assign rd_rx  = req && !bus_we && sel_rx;
  assign rx_fill = wp - rp;
  assign empty  = rx_fill == '0;
  assign full   = rx_fill == (AW+1)'(FIFO_DEPTH);
  assign pop    = rd_rx && !empty;
  assign push   = rx_act && rx_cnt == '0 && rx_bit == 4'd9 && rx_s && !full;
  assign uart_tx = tx_sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= req;
      if (req) begin
        if (!bus_we && sel_rx)      bus_rdata <= empty ? '0 : {24'b0, mem[rp[AW-1:0]]};
        else if (!bus_we && sel_st) bus_rdata <= {30'b0, !empty, tx_busy};
        else                        bus_rdata <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_bit  <= '0;
    end else if (wr_tx) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, bus_wdata[7:0], 1'b0};
      tx_cnt  <= '0;
      tx_bit  <= '0;
    end else if (tx_busy) begin
      if (tx_cnt == CW'(DIV-1)) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[9:1]};
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
        else                tx_bit  <= tx_bit + 4'd1;
      end else begin
        tx_cnt <= tx_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= uart_rx;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_act <= 1'b0;
      rx_cnt <= '0;
      rx_bit <= '0;
      rx_sh  <= '0;
    end else if (!rx_act) begin
      if (!rx_s) begin
        rx_act <= 1'b1;
        rx_cnt <= CW'(HALF-1);
        rx_bit <= '0;
      end
    end else if (rx_cnt != '0) begin
      rx_cnt <= rx_cnt - CW'(1);
    end else begin
      rx_cnt <= CW'(DIV-1);
      rx_bit <= rx_bit + 4'd1;
      if (rx_bit == 4'd0) begin
        if (rx_s) rx_act <= 1'b0;
      end else if (rx_bit == 4'd9) begin
        rx_act <= 1'b0;
      end else begin
        rx_sh <= {rx_s, rx_sh[7:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + (AW+1)'(1);
      if (pop)  rp <= rp + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= rx_sh;

endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int OFS_W = 12,
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic             bus_we,
  input logic [OFS_W-1:0] bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             uart_tx,
  input logic             tx_busy,
  input logic [AW:0]      fill
);
  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> $past(bus_valid));

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> uart_tx);

  a_r9_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));

  a_r7_fill_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill == $past(fill) || fill == $past(fill) + (AW+1)'(1) ||
              fill + (AW+1)'(1) == $past(fill)));

  a_r10_status_upper: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && $past(!bus_we && bus_addr == OFS_W'('h8))) |-> bus_rdata[31:2] == '0);

  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && $past(!bus_we && bus_addr == OFS_W'('h4) && fill == '0)) |-> bus_rdata == '0);
endmodule

bind uart_mmio uart_mmio_chk #(.OFS_W(OFS_W), .AW(AW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .uart_tx(uart_tx), .tx_busy(tx_busy), .fill(rx_fill)
);

// File: tb/tb_uart_mmio.sv
module tb_uart_mmio;
  localparam int DIV = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 1'b0, bus_we = 1'b0, bus_ready;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic uart_tx, uart_rx = 1'b1;

  int n_chk = 0, n_fail = 0, frames = 0;
  logic [7:0] last_byte = '0;
  logic last_stop = 1'b0;
  bit reported = 0;

  always #4 clk = ~clk;

  uart_mmio #(.CLK_HZ(1_000_000), .BAUD(125_000), .FIFO_DEPTH(16), .OFS_W(12)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .uart_tx(uart_tx), .uart_rx(uart_rx));

  function automatic logic [31:0] exp_status(input logic busy, input int queued);
    return {30'b0, queued != 0, busy};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  endtask

  task automatic bus_xfer(input logic we, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] q);
    int w;
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    w = 0;
    do begin @(negedge clk); w++; end while (!bus_ready && w < 20);
    q = bus_rdata;
    bus_valid = 1'b0;
    check(w == 1, "R2 ack latency", 32'(w), 32'd1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus_xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    bus_xfer(1'b0, a, 32'h0, q);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv);
    logic [9:0] fr;
    fr = {stopv, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      uart_rx = fr[i];
      repeat (DIV) @(negedge clk);
    end
    uart_rx = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_frames(input int target);
    int t;
    t = 0;
    while (frames < target && t < 300) begin @(negedge clk); t++; end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && uart_tx == 1'b0) begin
        logic [7:0] b;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          repeat (DIV) @(negedge clk);
          b[k] = uart_tx;
        end
        repeat (DIV) @(negedge clk);
        last_stop = uart_tx;
        last_byte = b;
        frames++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] q;
    logic [7:0] b;
    logic [7:0] ref_q[$];
    int f0;
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(uart_tx == 1'b1, "R1 tx idle", 32'(uart_tx), 32'd1);
    check(bus_ready == 1'b0, "R1 ready low", 32'(bus_ready), 32'd0);
    rd(12'h8, q);
    check(q == exp_status(1'b0, 0), "R1 status", q, exp_status(1'b0, 0));

    for (int i = 0; i < 6; i++) begin
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
      f0 = frames;
      wr(12'h0, {24'hABCDEF, b});
      rd(12'h8, q);
      check(q == exp_status(1'b1, 0), "R4 busy during frame", q, exp_status(1'b1, 0));
      wait_frames(f0 + 1);
      check(frames == f0 + 1, "R3 frame seen", 32'(frames), 32'(f0 + 1));
      check(last_byte == b, "R3 frame data", 32'(last_byte), 32'(b));
      check(last_stop == 1'b1, "R3 stop bit", 32'(last_stop), 32'd1);
      repeat (10) @(negedge clk);
      rd(12'h8, q);
      check(q == exp_status(1'b0, 0), "R4 idle after frame", q, exp_status(1'b0, 0));
    end

    f0 = frames;
    wr(12'h0, 32'hA5);
    wr(12'h0, 32'h3C);
    wait_frames(f0 + 1);
    check(last_byte == 8'hA5, "R5 frame unchanged", 32'(last_byte), 32'hA5);
    repeat (120) @(negedge clk);
    check(frames == f0 + 1, "R5 no extra frame", 32'(frames), 32'(f0 + 1));

    ref_q.delete();
    for (int i = 0; i < 5; i++) begin
      b = 8'($urandom);
      ref_q.push_back(b);
      send_rx(b, 1'b1);
    end
    rd(12'h8, q);
    check(q == exp_status(1'b0, ref_q.size()), "R6 data waiting", q, exp_status(1'b0, ref_q.size()));
    while (ref_q.size() > 0) begin
      b = ref_q.pop_front();
      rd(12'h4, q);
      check(q == {24'b0, b}, "R7 pop order", q, {24'b0, b});
    end
    rd(12'h8, q);
    check(q == exp_status(1'b0, 0), "R6 drained", q, exp_status(1'b0, 0));

    rd(12'h4, q);
    check(q == 32'h0, "R8 empty read", q, 32'h0);
    rd(12'h8, q);
    check(q == exp_status(1'b0, 0), "R8 still empty", q, exp_status(1'b0, 0));

    for (int i = 0; i < 18; i++) begin
      b = (i == 0) ? 8'h01 : 8'($urandom);
      if (i < 16) ref_q.push_back(b);
      send_rx(b, 1'b1);
    end
    for (int i = 0; i < 16; i++) begin
      b = ref_q.pop_front();
      rd(12'h4, q);
      check(q == {24'b0, b}, "R9 stored bytes", q, {24'b0, b});
    end
    rd(12'h4, q);
    check(q == 32'h0, "R9 overflow dropped", q, 32'h0);

    send_rx(8'h5A, 1'b0);
    repeat (30) @(negedge clk);
    rd(12'h8, q);
    check(q == exp_status(1'b0, 0), "R11 bad stop discarded", q, exp_status(1'b0, 0));

    @(negedge clk);
    uart_rx = 1'b0;
    repeat (2) @(negedge clk);
    uart_rx = 1'b1;
    repeat (30) @(negedge clk);
    rd(12'h8, q);
    check(q == exp_status(1'b0, 0), "R12 pulse ignored", q, exp_status(1'b0, 0));
    send_rx(8'h81, 1'b1);
    rd(12'h4, q);
    check(q == 32'h81, "R12 next frame ok", q, 32'h81);

    rd(12'hC, q);
    check(q == 32'h0, "R10 unmapped read", q, 32'h0);
    rd(12'h0, q);
    check(q == 32'h0, "R10 tx reg read", q, 32'h0);
    f0 = frames;
    wr(12'h8, 32'hFFFF_FFFF);
    wr(12'h4, 32'h0000_0077);
    wr(12'h10, 32'h0000_0055);
    repeat (40) @(negedge clk);
    rd(12'h8, q);
    check(q == exp_status(1'b0, 0), "R10 writes ignored", q, exp_status(1'b0, 0));
    check(frames == f0, "R10 no frame", 32'(frames), 32'(f0));

    report();
  end
endmodule